// File: doc/BRIEF.md
# Timer External Capture and Counter Unit

This unit sits beside a 24-bit up-timer and conditions two external inputs for it. The count input can act as the clock of an event counter: every accepted edge of the chosen polarity produces a one-cycle increment strobe that the timer uses to advance. The capture input watches for a programmable edge. Each detected edge either copies the timer's present count into a capture register and raises a capture flag, or emits a one-cycle strobe that clears the timer's up counter.

Both inputs pass through a two-flop synchronizer. Each input then goes through its own optional debounce filter before edge detection. The capture input can come from the external pin or from a comparator output. The capture flag is sticky, and software clears it by writing 1. A capture interrupt is asserted for as long as the flag and its enable are both set. Configuration arrives as static inputs from the timer's register block.

Top module: `tmr_ext_unit`

## Requirements
- R1: After reset, countInc, counterReset, capFlag and capIrq are 0 and capData is 0.
- R2: With cfgCountRising = 1, each rising edge of the count input gives exactly one countInc pulse one cycle wide, and falling edges give none. With cfgCountRising = 0, the roles of the two edges are swapped.
- R3: cfgCapEdge selects the capture edge. 2'b00 detects high-to-low, 2'b01 detects low-to-high and 2'b10 detects both.
- R4: With cfgCapEdge = 2'b11, no capture-input transition causes a capture or a counter reset.
- R5: With cfgCapEnable = 0, capture-input transitions change neither capFlag, nor capData, nor counterReset.
- R6: With cfgCapResets = 0, a detected capture edge loads timerCount, as it stood in the cycle of detection, into capData and sets capFlag. Both are visible one cycle later.
- R7: With cfgCapResets = 1, a detected capture edge gives a single one-cycle counterReset pulse and leaves capData and capFlag unchanged.
- R8: A capFlagClear pulse clears capFlag in the next cycle. If a capture happens in the same cycle as a clear, the capture wins and the flag stays set.
- R9: capIrq is high exactly when capFlag and cfgCapIrqEn are both 1.
- R10: With debounce enabled on an input, a new level is accepted only after it has held for 3 consecutive synchronized samples. Shorter pulses are dropped. An accepted edge arrives 2 cycles later than it would without debounce.
- R11: The debounce enables of the two inputs act independently of each other.
- R12: cfgCapFromCmp = 0 takes the capture input from capPinIn, and 1 takes it from cmpOutIn. The unselected source has no effect.
- R13: Without debounce, a transition driven before clock edge 1 produces its strobe in the cycle after edge 3, because of 2 synchronizer flops and 1 filter flop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cntPinIn | input | 1 | External count input (asynchronous) |
| capPinIn | input | 1 | External capture input (asynchronous) |
| cmpOutIn | input | 1 | Comparator output, alternative capture source |
| cfgCapFromCmp | input | 1 | 1: capture source is cmpOutIn, 0: capPinIn |
| cfgCountRising | input | 1 | 1: count rising edges, 0: count falling edges |
| cfgCountDebounce | input | 1 | Debounce enable for the count input |
| cfgCapEdge | input | 2 | Capture edge: 00 fall, 01 rise, 10 both, 11 none |
| cfgCapEnable | input | 1 | Capture input function enable |
| cfgCapResets | input | 1 | 1: edge resets the counter, 0: edge captures |
| cfgCapIrqEn | input | 1 | Capture interrupt enable |
| cfgCapDebounce | input | 1 | Debounce enable for the capture input |
| capFlagClear | input | 1 | Write-1-to-clear strobe for capFlag |
| timerCount | input | 24 | Present value of the timer's up counter |
| countInc | output | 1 | One-cycle event-count increment strobe |
| counterReset | output | 1 | One-cycle up-counter reset strobe |
| capData | output | 24 | Last captured count |
| capFlag | output | 1 | Capture flag |
| capIrq | output | 1 | Capture interrupt |

## Verification
The bench counts cycles exactly from each stimulus. A filter that accepts a level one sample early or late moves the strobe by a cycle. A design that captures the count from the wrong cycle loads a value that differs by one. Two-cycle glitches are driven with debounce on and must leave the flag untouched, while the same glitch without debounce must fire on both edges. The reserved edge code, a clear that lands in the same cycle as a capture, and a toggling but unselected capture source are also driven. A design that let a clear beat a capture, or that decoded code 11 as an edge, would drop or invent a flag.

// File: rtl/tmr_ext_pkg.sv
package tmr_ext_pkg;

  // capture edge selection codes
  localparam logic [1:0] EDGE_FALL = 2'b00;
  localparam logic [1:0] EDGE_RISE = 2'b01;
  localparam logic [1:0] EDGE_BOTH = 2'b10;

  // strobes from control to datapath / timer
  typedef struct packed {
    logic countInc;
    logic capLatch;
    logic cntReset;
  } extStrobes_t;

endpackage

// File: rtl/tmr_pin_filter.sv
module tmr_pin_filter #(
  parameter int DB_LEN = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  input  logic dbEn,
  output logic level
);
  localparam int RUN_W = $clog2(DB_LEN + 1);

  logic [1:0]       syncReg;
  logic             syncLevel;
  logic [RUN_W-1:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncReg <= '0;
    else       syncReg <= {syncReg[0], rawIn};
  end
  assign syncLevel = syncReg[1];

  // accept a new level after DB_LEN consecutive differing samples
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      level  <= 1'b0;
      runLen <= '0;
    end else if (!dbEn) begin
      level  <= syncLevel;
      runLen <= '0;
    end else if (syncLevel == level) begin
      runLen <= '0;
    end else if (runLen == RUN_W'(DB_LEN - 1)) begin
      level  <= syncLevel;
      runLen <= '0;
    end else begin
      runLen <= runLen + 1'b1;
    end
  end

  generate
    if (DB_LEN >= 3) begin : g_dbChk
      // R10: a filtered change is backed by a stable synchronized history
      a_r10_stable_before_accept: assert property (@(posedge clk) disable iff (!rstN)
        (dbEn && $past(dbEn) && level != $past(level)) |->
          ($past(syncLevel) == level && $past(syncLevel, 2) == level));
    end
  endgenerate
endmodule

// File: rtl/tmr_ext_ctrl.sv
module tmr_ext_ctrl
  import tmr_ext_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cntLevel,
  input  logic        capLevel,
  input  logic        cfgCountRising,
  input  logic [1:0]  cfgCapEdge,
  input  logic        cfgCapEnable,
  input  logic        cfgCapResets,
  output extStrobes_t strobes
);
  logic prevCnt, prevCap;
  logic cntRise, cntFall, capRise, capFall;
  logic capHit, capEvent;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevCnt <= 1'b0;
      prevCap <= 1'b0;
    end else begin
      prevCnt <= cntLevel;
      prevCap <= capLevel;
    end
  end

  assign cntRise = cntLevel & ~prevCnt;
  assign cntFall = ~cntLevel & prevCnt;
  assign capRise = capLevel & ~prevCap;
  assign capFall = ~capLevel & prevCap;

  always_comb begin
    case (cfgCapEdge)
      EDGE_FALL: capHit = capFall;
      EDGE_RISE: capHit = capRise;
      EDGE_BOTH: capHit = capRise | capFall;
      default:   capHit = 1'b0;
    endcase
  end

  assign capEvent         = capHit & cfgCapEnable;
  assign strobes.countInc = cfgCountRising ? cntRise : cntFall;
  assign strobes.capLatch = capEvent & ~cfgCapResets;
  assign strobes.cntReset = capEvent & cfgCapResets;

  // R2: increment strobe lasts a single cycle
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    strobes.countInc |=> !strobes.countInc);
  // R2: strobe only after the filtered level settles at the chosen polarity
  a_r2_polarity: assert property (@(posedge clk) disable iff (!rstN)
    strobes.countInc |-> (cntLevel == cfgCountRising));
  // R4: reserved edge code never acts
  a_r4_reserved_silent: assert property (@(posedge clk) disable iff (!rstN)
    (cfgCapEdge == 2'b11) |-> !(strobes.capLatch || strobes.cntReset));
  // R5: disabled capture function never acts
  a_r5_disabled_silent: assert property (@(posedge clk) disable iff (!rstN)
    !cfgCapEnable |-> !(strobes.capLatch || strobes.cntReset));
  // R7: an edge takes one route only
  a_r7_one_route: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.capLatch && strobes.cntReset));
endmodule

// File: rtl/tmr_ext_datapath.sv
module tmr_ext_datapath
  import tmr_ext_pkg::*;
#(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rstN,
  input  extStrobes_t   strobes,
  input  logic [CW-1:0] timerCount,
  input  logic          flagClear,
  input  logic          irqEn,
  output logic [CW-1:0] capData,
  output logic          capFlag,
  output logic          capIrq
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capData <= '0;
      capFlag <= 1'b0;
    end else begin
      if (strobes.capLatch) begin
        capData <= timerCount;
        capFlag <= 1'b1;
      end else if (flagClear) begin
        capFlag <= 1'b0;
      end
    end
  end

  assign capIrq = capFlag & irqEn;

  // R6: capture loads the count of the detection cycle and sets the flag
  a_r6_latch: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capLatch |=> (capFlag && capData == $past(timerCount)));
  // R7: without a latch strobe the data holds
  a_r7_data_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capLatch |=> $stable(capData));
  // R8: clear without a concurrent capture drops the flag
  a_r8_clear: assert property (@(posedge clk) disable iff (!rstN)
    (flagClear && !strobes.capLatch) |=> !capFlag);
  // R8: flag is sticky until cleared
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (capFlag && !flagClear) |=> capFlag);
endmodule

// File: rtl/tmr_ext_unit.sv
module tmr_ext_unit
  import tmr_ext_pkg::*;
#(
  parameter int CW     = 24,
  parameter int DB_LEN = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cntPinIn,
  input  logic          capPinIn,
  input  logic          cmpOutIn,
  input  logic          cfgCapFromCmp,
  input  logic          cfgCountRising,
  input  logic          cfgCountDebounce,
  input  logic [1:0]    cfgCapEdge,
  input  logic          cfgCapEnable,
  input  logic          cfgCapResets,
  input  logic          cfgCapIrqEn,
  input  logic          cfgCapDebounce,
  input  logic          capFlagClear,
  input  logic [CW-1:0] timerCount,
  output logic          countInc,
  output logic          counterReset,
  output logic [CW-1:0] capData,
  output logic          capFlag,
  output logic          capIrq
);
  localparam int NPINS = 2; // index 0: count input, 1: capture input

  logic [NPINS-1:0] rawPins, dbEns, levels;
  extStrobes_t      strobes;

  assign rawPins = {(cfgCapFromCmp ? cmpOutIn : capPinIn), cntPinIn};
  assign dbEns   = {cfgCapDebounce, cfgCountDebounce};

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    tmr_pin_filter #(.DB_LEN(DB_LEN)) i_filter (
      .clk   (clk),
      .rstN  (rstN),
      .rawIn (rawPins[p]),
      .dbEn  (dbEns[p]),
      .level (levels[p])
    );
  end

  tmr_ext_ctrl i_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .cntLevel       (levels[0]),
    .capLevel       (levels[1]),
    .cfgCountRising (cfgCountRising),
    .cfgCapEdge     (cfgCapEdge),
    .cfgCapEnable   (cfgCapEnable),
    .cfgCapResets   (cfgCapResets),
    .strobes        (strobes)
  );

  tmr_ext_datapath #(.CW(CW)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .timerCount (timerCount),
    .flagClear  (capFlagClear),
    .irqEn      (cfgCapIrqEn),
    .capData    (capData),
    .capFlag    (capFlag),
    .capIrq     (capIrq)
  );

  assign countInc     = strobes.countInc;
  assign counterReset = strobes.cntReset;
endmodule

// File: tb/test_tmr_ext_unit.sv
module test_tmr_ext_unit;
  localparam int CW   = 24;
  localparam int NOBS = 12;

  logic clk = 1'b0, rstN = 1'b0;
  logic cntPinIn = 0, capPinIn = 0, cmpOutIn = 0;
  logic cfgCapFromCmp = 0, cfgCountRising = 1, cfgCountDebounce = 0;
  logic [1:0] cfgCapEdge = 2'b01;
  logic cfgCapEnable = 1, cfgCapResets = 0, cfgCapIrqEn = 0, cfgCapDebounce = 0;
  logic capFlagClear = 0;
  logic [CW-1:0] timerCount = 24'hABC000;
  logic countInc, counterReset, capFlag, capIrq;
  logic [CW-1:0] capData;

  int checks = 0, failures = 0;

  logic          obsInc [NOBS];
  logic          obsRst [NOBS];
  logic          obsFlag[NOBS];
  logic          obsIrq [NOBS];
  logic [CW-1:0] obsData[NOBS];
  logic [CW-1:0] obsTc  [NOBS];

  tmr_ext_unit i_tmr_ext_unit (
    .clk(clk), .rstN(rstN), .cntPinIn(cntPinIn), .capPinIn(capPinIn),
    .cmpOutIn(cmpOutIn), .cfgCapFromCmp(cfgCapFromCmp),
    .cfgCountRising(cfgCountRising), .cfgCountDebounce(cfgCountDebounce),
    .cfgCapEdge(cfgCapEdge), .cfgCapEnable(cfgCapEnable),
    .cfgCapResets(cfgCapResets), .cfgCapIrqEn(cfgCapIrqEn),
    .cfgCapDebounce(cfgCapDebounce), .capFlagClear(capFlagClear),
    .timerCount(timerCount), .countInc(countInc), .counterReset(counterReset),
    .capData(capData), .capFlag(capFlag), .capIrq(capIrq)
  );

  always #4 clk = ~clk;

  initial begin
    forever begin
      @(posedge clk);
      #1 timerCount = timerCount + 24'd1;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sample(input int i);
    obsInc[i] = countInc;  obsRst[i] = counterReset;
    obsFlag[i] = capFlag;  obsIrq[i] = capIrq;
    obsData[i] = capData;  obsTc[i]  = timerCount;
  endtask

  // which: 0 count pin, 1 capture pin, 2 comparator
  task automatic setPin(input int which, input logic v);
    case (which)
      0: cntPinIn = v;
      1: capPinIn = v;
      default: cmpOutIn = v;
    endcase
  endtask

  // drive a level at negedge 0, optional revert and clear; sample indices 0..NOBS-1
  task automatic stimulate(input int which, input logic lvl, input int revertAt, input int clearAt);
    @(negedge clk);
    sample(0);
    setPin(which, lvl);
    for (int i = 1; i < NOBS; i++) begin
      @(negedge clk);
      sample(i);
      if (i == revertAt) setPin(which, !lvl);
      capFlagClear = (i == clearAt);
    end
    capFlagClear = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic clearFlag();
    @(negedge clk); capFlagClear = 1;
    @(negedge clk); capFlagClear = 0;
  endtask

  function automatic int pulses(input logic arr[NOBS]);
    int n = 0;
    for (int i = 0; i < NOBS; i++) if (arr[i]) n++;
    return n;
  endfunction

  task automatic expectIncAt(input string req, input int idx);
    check(pulses(obsInc) == 1 && obsInc[idx], req, pulses(obsInc), 1);
  endtask

  task automatic expectCaptureAt(input string req, input int idx);
    check(!obsFlag[idx-1] && obsFlag[idx], req, obsFlag[idx], 1);
    check(obsData[idx] == obsTc[idx-1], req, obsData[idx], obsTc[idx-1]);
  endtask

  task automatic expectNoCapture(input string req, input logic [CW-1:0] prev);
    check(obsFlag[NOBS-1] == 0 && pulses(obsFlag) == 0, req, pulses(obsFlag), 0);
    check(obsData[NOBS-1] == prev, req, obsData[NOBS-1], prev);
    check(pulses(obsRst) == 0, req, pulses(obsRst), 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!countInc && !counterReset && !capFlag && !capIrq && capData == 0,
          "R1 reset state", {capFlag, countInc, counterReset}, 0);
  endtask

  task automatic t_count();
    cfgCountRising = 1;
    stimulate(0, 1, -1, -1); expectIncAt("R2 R13 rising counted at idx3", 3);
    stimulate(0, 0, -1, -1); check(pulses(obsInc) == 0, "R2 falling ignored", pulses(obsInc), 0);
    cfgCountRising = 0;
    stimulate(0, 1, -1, -1); check(pulses(obsInc) == 0, "R2 rising ignored", pulses(obsInc), 0);
    stimulate(0, 0, -1, -1); expectIncAt("R2 falling counted", 3);
    cfgCountRising = 1;
  endtask

  task automatic t_cap_edges();
    logic [CW-1:0] prev;
    cfgCapEdge = 2'b01;
    stimulate(1, 1, -1, -1); expectCaptureAt("R3 R6 rise capture", 4);
    clearFlag(); prev = capData;
    stimulate(1, 0, -1, -1); expectNoCapture("R3 fall ignored under 01", prev);
    cfgCapEdge = 2'b00;
    stimulate(1, 1, -1, -1); expectNoCapture("R3 rise ignored under 00", prev);
    stimulate(1, 0, -1, -1); expectCaptureAt("R3 fall capture", 4);
    clearFlag();
    cfgCapEdge = 2'b10;
    stimulate(1, 1, -1, -1); expectCaptureAt("R3 both: rise", 4);
    clearFlag();
    stimulate(1, 0, -1, -1); expectCaptureAt("R3 both: fall", 4);
    clearFlag(); prev = capData;
    cfgCapEdge = 2'b11;
    stimulate(1, 1, -1, -1); expectNoCapture("R4 reserved rise", prev);
    stimulate(1, 0, -1, -1); expectNoCapture("R4 reserved fall", prev);
    cfgCapEdge = 2'b01;
  endtask

  task automatic t_disable_and_route();
    logic [CW-1:0] prev = capData;
    cfgCapEnable = 0;
    stimulate(1, 1, -1, -1); expectNoCapture("R5 disabled rise", prev);
    stimulate(1, 0, -1, -1);
    cfgCapEnable = 1; cfgCapResets = 1;
    stimulate(1, 1, -1, -1);
    check(pulses(obsRst) == 1 && obsRst[3], "R7 reset strobe idx3", pulses(obsRst), 1);
    check(pulses(obsFlag) == 0 && obsData[NOBS-1] == prev, "R7 no capture", obsData[NOBS-1], prev);
    stimulate(1, 0, -1, -1);
    cfgCapResets = 0;
  endtask

  task automatic t_flag_irq();
    cfgCapIrqEn = 0;
    stimulate(1, 1, -1, -1);
    check(obsFlag[5] && !obsIrq[5], "R9 irq masked", obsIrq[5], 0);
    cfgCapIrqEn = 1;
    @(negedge clk);
    check(capIrq, "R9 irq asserted", capIrq, 1);
    @(negedge clk); capFlagClear = 1;
    @(negedge clk); capFlagClear = 0;
    check(!capFlag && !capIrq, "R8 R9 clear drops flag and irq", capFlag, 0);
    stimulate(1, 0, -1, -1);
    // clear applied on the same edge as the capture (posedge 4)
    stimulate(1, 1, -1, 3);
    check(obsFlag[4] && obsFlag[5], "R8 capture beats clear", obsFlag[5], 1);
    clearFlag();
    stimulate(1, 0, -1, -1);
    cfgCapIrqEn = 0;
  endtask

  task automatic t_debounce();
    logic [CW-1:0] prev;
    cfgCapDebounce = 1; cfgCountDebounce = 0;
    stimulate(1, 1, -1, -1); expectCaptureAt("R10 debounced capture at idx6", 6);
    clearFlag();
    stimulate(1, 0, -1, -1); prev = capData;
    stimulate(1, 1, 2, -1); expectNoCapture("R10 short glitch dropped", prev);
    stimulate(0, 1, -1, -1); expectIncAt("R11 count not debounced", 3);
    stimulate(0, 0, -1, -1);
    cfgCountDebounce = 1;
    stimulate(0, 1, -1, -1); expectIncAt("R10 R11 count debounced idx5", 5);
    stimulate(0, 0, -1, -1);
    cfgCountDebounce = 0; cfgCapDebounce = 0; cfgCapEdge = 2'b10;
    stimulate(1, 1, 2, -1);
    check(obsFlag[NOBS-1], "R10 glitch passes without debounce", obsFlag[NOBS-1], 1);
    clearFlag();
    cfgCapEdge = 2'b01;
  endtask

  task automatic t_source();
    logic [CW-1:0] prev = capData;
    cfgCapFromCmp = 1;
    stimulate(1, 1, -1, -1); expectNoCapture("R12 pin unselected", prev);
    stimulate(1, 0, -1, -1);
    stimulate(2, 1, -1, -1); expectCaptureAt("R12 comparator capture", 4);
    clearFlag();
    cfgCapFromCmp = 0;
    prev = capData;
    stimulate(2, 0, -1, -1); expectNoCapture("R12 comparator unselected", prev);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    t_reset();
    t_count();
    t_cap_edges();
    t_disable_and_route();
    t_flag_irq();
    t_debounce();
    t_source();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule